// File: doc/BRIEF.md
# Predict-Taken Branch Fetch Controller

This block steers instruction fetch in a five-stage pipeline that guesses every branch is taken. When a branch sits in decode, the block works out the destination (the address after the branch plus a sign-extended, word-scaled displacement). It loads that destination into the fetch PC and turns the instruction being fetched behind the branch into a bubble. The first fetch after that comes from the branch destination. The branch address plus four is kept on the side as the recovery address.

The condition is evaluated one stage later. If the branch really is taken, fetch carries on from the destination path, and the branch has cost one bubble in all. If it is not taken, the one speculative instruction is squashed into a NOP and fetch restarts at the saved recovery address, for a cost of two cycles. If the resolution is late because the execute stage is held, fetch waits with the PC frozen and a bubble per cycle. Only one branch is tracked at a time, so a branch shown at decode while another is pending is ignored.

Top module: `br_ctrl`

## Requirements
- R1: In reset and in the first cycle after it, `fetch_pc` equals the `RESET_PC` parameter (default 0), `pc_sel` is 0, `pc_en` is 1, and `ifid_bubble` and `spec_flush` are 0.
- R2: With no branch in decode and none pending, `pc_sel` is 0 (sequential) and `fetch_pc` advances by 4 at every clock edge.
- R3: When `id_valid` and `id_branch` are high and no branch is pending, in that cycle `pc_sel` is 1 (target) and `ifid_bubble` is 1. After the edge, `fetch_pc` equals `id_pc + 4 + (sign-extended id_disp * 4)`, computed modulo 2^AW.
- R4: While a branch is pending and `ex_resolve` is low, `pc_en` is 0, `ifid_bubble` is 1 and `fetch_pc` holds its value.
- R5: On `ex_resolve` with `ex_taken` high for the pending branch, `pc_sel` is 0, `pc_en` is 1, and `ifid_bubble` and `spec_flush` are 0. After the edge, `fetch_pc` is the target plus 4. A branch resolved in the cycle after decode has caused exactly one bubble cycle.
- R6: On `ex_resolve` with `ex_taken` low for the pending branch, `spec_flush` and `ifid_bubble` are 1, `pc_sel` is 2 (fall-through) and `redirect_pc` equals the branch's `id_pc + 4`. After the edge, `fetch_pc` equals that value. A branch resolved in the cycle after decode has caused exactly two bubble cycles.
- R7: A branch presented at decode while another is pending is ignored: the PC does not move to its target, and no second recovery address is stored.
- R8: `ex_resolve` with no branch pending is ignored. Fetch stays sequential, and `spec_flush` and `ifid_bubble` stay 0.
- R9: `spec_flush` is 1 only in a cycle that resolves a pending branch as not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_branch | input | 1 | Instruction in decode is a conditional branch |
| id_pc | input | AW | Address of the instruction in decode |
| id_disp | input | DW | Signed word displacement of the branch |
| ex_resolve | input | 1 | The pending branch's condition is evaluated this cycle |
| ex_taken | input | 1 | Condition result: 1 taken, 0 not taken |
| fetch_pc | output | AW | Current fetch address |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 target, 2 fall-through |
| pc_en | output | 1 | Fetch PC is updated at this edge |
| ifid_bubble | output | 1 | Write a NOP into the IF/ID register at this edge |
| spec_flush | output | 1 | Squash the speculatively fetched target instruction |
| redirect_pc | output | AW | Saved fall-through address of the pending branch |

## Verification
Two functions can act in the same cycle. The resolution of a pending branch can arrive in the same cycle as a new branch indication at decode. Stalled waits can also arrive while decode keeps flagging a branch. The bench provokes both by driving a second branch with a different address and displacement in every wait cycle and in the resolve cycle. It then judges by the fetch address after the edge: that address must be the first branch's target, target plus four, or fall-through, and never the second branch's target. Displacement sweeps cover positive, negative, zero and extreme values, each with both outcomes and with zero to two wait cycles, and the bench counts bubble cycles per branch against 1 + waits (+1 if not taken).

// File: rtl/br_ctrl_pkg.sv
package br_ctrl_pkg;
    localparam int INSN_BYTES = 4;

    typedef enum logic [1:0] {
        PCS_SEQ  = 2'd0,
        PCS_TGT  = 2'd1,
        PCS_FALL = 2'd2
    } pc_src_e;

    typedef struct packed {
        pc_src_e src;
        logic    en;
        logic    bubble;
        logic    flush;
        logic    load;
        logic    clear;
    } fetch_ctl_t;
endpackage

// File: rtl/br_target.sv
module br_target #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] seq_pc,
    output logic [AW-1:0] tgt_pc
);
    import br_ctrl_pkg::*;
    localparam int EXT = AW - DW;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT{disp[DW-1]}}, disp};
        seq_pc   = pc + AW'(INSN_BYTES);
        tgt_pc   = seq_pc + (disp_ext << 2);
    end
endmodule

// File: rtl/br_track.sv
module br_track #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          clear,
    input  logic [AW-1:0] ft_in,
    output logic          pending,
    output logic [AW-1:0] ft_pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            ft_pc   <= '0;
        end else if (load) begin
            pending <= 1'b1;
            ft_pc   <= ft_in;
        end else if (clear) begin
            pending <= 1'b0;
        end
    end

    // R7: only one unresolved branch is ever tracked
    assert_single_track_R7: assert property (@(posedge clk) disable iff (rst)
        (pending && !clear) |-> !load);

    // R7: the saved recovery address survives until resolution
    assert_ft_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (pending && !clear) |=> $stable(ft_pc));
endmodule

// File: rtl/br_ctrl.sv
module br_ctrl #(
    parameter int          AW       = 32,
    parameter int          DW       = 16,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          id_valid,
    input  logic          id_branch,
    input  logic [AW-1:0] id_pc,
    input  logic [DW-1:0] id_disp,
    input  logic          ex_resolve,
    input  logic          ex_taken,
    output logic [AW-1:0] fetch_pc,
    output logic [1:0]    pc_sel,
    output logic          pc_en,
    output logic          ifid_bubble,
    output logic          spec_flush,
    output logic [AW-1:0] redirect_pc
);
    import br_ctrl_pkg::*;

    logic [AW-1:0] id_seq_pc;
    logic [AW-1:0] id_tgt_pc;
    logic          pending;
    logic [AW-1:0] ft_pc;
    fetch_ctl_t    ctl;
    logic [AW-1:0] next_pc;

    br_target #(.AW(AW), .DW(DW)) u_target (
        .pc     (id_pc),
        .disp   (id_disp),
        .seq_pc (id_seq_pc),
        .tgt_pc (id_tgt_pc)
    );

    br_track #(.AW(AW)) u_track (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.load),
        .clear   (ctl.clear),
        .ft_in   (id_seq_pc),
        .pending (pending),
        .ft_pc   (ft_pc)
    );

    always_comb begin
        ctl = '{src: PCS_SEQ, en: 1'b1, bubble: 1'b0, flush: 1'b0,
                load: 1'b0, clear: 1'b0};
        if (pending) begin
            if (ex_resolve) begin
                ctl.clear = 1'b1;
                if (!ex_taken) begin
                    ctl.src    = PCS_FALL;
                    ctl.bubble = 1'b1;
                    ctl.flush  = 1'b1;
                end
            end else begin
                ctl.en     = 1'b0;
                ctl.bubble = 1'b1;
            end
        end else if (id_valid && id_branch) begin
            ctl.src    = PCS_TGT;
            ctl.bubble = 1'b1;
            ctl.load   = 1'b1;
        end
    end

    always_comb begin
        unique case (ctl.src)
            PCS_TGT:  next_pc = id_tgt_pc;
            PCS_FALL: next_pc = ft_pc;
            default:  next_pc = fetch_pc + AW'(INSN_BYTES);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            fetch_pc <= AW'(RESET_PC);
        else if (ctl.en)
            fetch_pc <= next_pc;
    end

    assign pc_sel      = ctl.src;
    assign pc_en       = ctl.en;
    assign ifid_bubble = ctl.bubble;
    assign spec_flush  = ctl.flush;
    assign redirect_pc = ft_pc;

    // R3: a decoded branch redirects fetch to its computed destination
    assert_target_load_R3: assert property (@(posedge clk) disable iff (rst)
        (pc_sel == 2'd1) |=> fetch_pc == $past(id_tgt_pc));

    // R4: a disabled PC keeps its value
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !pc_en |=> $stable(fetch_pc));

    // R6: recovery lands on the saved fall-through address
    assert_recover_R6: assert property (@(posedge clk) disable iff (rst)
        spec_flush |=> fetch_pc == $past(redirect_pc));

    // R9: a squash only happens while a branch is outstanding and resolving
    assert_flush_cause_R9: assert property (@(posedge clk) disable iff (rst)
        spec_flush |-> (pending && ex_resolve && !ex_taken && ifid_bubble));

    // R8: with nothing outstanding, a resolution cannot disturb fetch
    assert_stray_resolve_R8: assert property (@(posedge clk) disable iff (rst)
        (!pending && ex_resolve && !(id_valid && id_branch))
        |=> fetch_pc == $past(fetch_pc) + AW'(INSN_BYTES));
endmodule

// File: tb/test_br_ctrl.sv
`timescale 1ns/1ps
module test_br_ctrl;
    localparam int AW = 32;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          id_valid;
    logic          id_branch;
    logic [AW-1:0] id_pc;
    logic [DW-1:0] id_disp;
    logic          ex_resolve;
    logic          ex_taken;
    logic [AW-1:0] fetch_pc;
    logic [1:0]    pc_sel;
    logic          pc_en;
    logic          ifid_bubble;
    logic          spec_flush;
    logic [AW-1:0] redirect_pc;

    int checks = 0;
    int errors = 0;
    int bubbles;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    br_ctrl #(.AW(AW), .DW(DW), .RESET_PC(32'h0)) i_br_ctrl (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_branch(id_branch),
        .id_pc(id_pc), .id_disp(id_disp), .ex_resolve(ex_resolve),
        .ex_taken(ex_taken), .fetch_pc(fetch_pc), .pc_sel(pc_sel),
        .pc_en(pc_en), .ifid_bubble(ifid_bubble), .spec_flush(spec_flush),
        .redirect_pc(redirect_pc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dest(input logic [31:0] pc, input logic [15:0] d);
        int dv;
        dv = $signed(d);
        return pc + 32'd4 + 32'(dv * 4);
    endfunction

    task automatic step();
        if (ifid_bubble) bubbles++;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        id_valid = 0; id_branch = 0; ex_resolve = 0; ex_taken = 0;
    endtask

    task automatic run_branch(input logic [31:0] pc, input logic [15:0] d,
                              input bit taken, input int waits);
        logic [31:0] tgt;
        tgt = dest(pc, d);
        bubbles = 0;
        @(negedge clk);
        id_valid = 1; id_branch = 1; id_pc = pc; id_disp = d; ex_resolve = 0;
        #0.5;
        check(pc_sel == 2'd1, "R3 sel", 32'(pc_sel), 32'd1);
        check(ifid_bubble == 1'b1, "R3 bubble", 32'(ifid_bubble), 32'd1);
        step();
        check(fetch_pc == tgt, "R3 target", fetch_pc, tgt);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            id_valid = 1; id_branch = 1; id_pc = pc ^ 32'h0000_1000; id_disp = ~d;
            #0.5;
            check(pc_en == 1'b0 && ifid_bubble == 1'b1, "R4 stall",
                  32'({pc_en, ifid_bubble}), 32'b01);
            step();
            check(fetch_pc == tgt, "R4/R7 hold", fetch_pc, tgt);
        end
        @(negedge clk);
        id_valid = 1; id_branch = 1; id_pc = pc + 32'h40; id_disp = 16'h0100;
        ex_resolve = 1; ex_taken = taken;
        #0.5;
        if (taken) begin
            check(pc_sel == 2'd0 && !ifid_bubble && !spec_flush && pc_en, "R5 ctl",
                  32'({pc_sel, pc_en, ifid_bubble, spec_flush}), 32'b00100);
        end else begin
            check(spec_flush && ifid_bubble && pc_sel == 2'd2, "R6 ctl",
                  32'({pc_sel, ifid_bubble, spec_flush}), 32'b1011);
            check(redirect_pc == pc + 32'd4, "R6 redirect", redirect_pc, pc + 32'd4);
        end
        step();
        if (taken) check(fetch_pc == tgt + 32'd4, "R5/R7 pc", fetch_pc, tgt + 32'd4);
        else       check(fetch_pc == pc + 32'd4, "R6/R7 pc", fetch_pc, pc + 32'd4);
        if (waits == 0) begin
            if (taken) check(bubbles == 1, "R5 penalty", bubbles, 1);
            else       check(bubbles == 2, "R6 penalty", bubbles, 2);
        end else begin
            check(bubbles == 1 + waits + (taken ? 0 : 1), "R4 penalty",
                  bubbles, 1 + waits + (taken ? 0 : 1));
        end
        idle_inputs();
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] p0;
        logic [15:0] disps [6];
        disps[0] = 16'h0000; disps[1] = 16'h0005; disps[2] = 16'hFFFD;
        disps[3] = 16'h7FFF; disps[4] = 16'h8000; disps[5] = 16'hFFFF;
        rst = 1; id_valid = 0; id_branch = 0; id_pc = '0; id_disp = '0;
        ex_resolve = 0; ex_taken = 0;
        repeat (3) @(posedge clk);
        #1;
        check(fetch_pc == 32'h0, "R1 reset pc", fetch_pc, 32'h0);
        @(negedge clk);
        rst = 0;
        #0.5;
        check(pc_sel == 2'd0 && pc_en && !ifid_bubble && !spec_flush, "R1 ctl",
              32'({pc_sel, pc_en, ifid_bubble, spec_flush}), 32'b00100);
        for (int i = 0; i < 4; i++) begin
            p0 = fetch_pc;
            step();
            check(fetch_pc == p0 + 32'd4, "R2 seq", fetch_pc, p0 + 32'd4);
        end
        // stray resolutions with nothing outstanding
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            ex_resolve = 1; ex_taken = t[0];
            #0.5;
            check(!spec_flush && !ifid_bubble && pc_sel == 2'd0, "R8 ctl",
                  32'({pc_sel, ifid_bubble, spec_flush}), 32'd0);
            p0 = fetch_pc;
            step();
            check(fetch_pc == p0 + 32'd4, "R8 pc", fetch_pc, p0 + 32'd4);
            idle_inputs();
        end
        for (int k = 0; k < 6; k++)
            for (int tk = 0; tk < 2; tk++)
                for (int w = 0; w < 3; w++)
                    run_branch(32'h0001_0000 + 32'(k * 256 + w * 16), disps[k], tk[0], w);
        // wrap-around of the destination
        run_branch(32'hFFFF_FFF8, 16'h0004, 1'b1, 0);
        run_branch(32'h0000_0004, 16'hFFF0, 1'b0, 0);
        // spec_flush never appears in ordinary sequential fetch (R9)
        for (int i = 0; i < 3; i++) begin
            #0.5;
            check(!spec_flush, "R9 no flush", 32'(spec_flush), 32'd0);
            step();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule